// File: doc/BRIEF.md
# Micro-op Decode Slot Allocator

This block sits between an in-order queue of complex instructions and the micro-op pipeline. Each clock it looks at up to three queue entries, oldest first. Each entry is a valid bit, a tag and the number of micro-ops the instruction expands into. The block decides how many entries the queue may drop this cycle, reported on `in_take`. It also drives a packed group of micro-op slots. Each slot names its parent tag, the slot's position inside that parent's expansion, and whether it is the parent's final micro-op.

The oldest lane is the wide one. It can issue up to four micro-ops of its instruction per cycle. An instruction longer than that is split over consecutive cycles, and the block keeps a running offset for it. The two younger lanes take only single-micro-op instructions. A longer one waits until it becomes the oldest. A per-cycle budget caps the total slot count. A downstream ready signal freezes the block. An instruction that claims zero micro-ops is dropped and flagged instead of emitted. All slot outputs are combinational from the current queue view and the split offset. The offset is the only state.

Top module: `uop_slot_alloc`

## Requirements
- R1: Up to three instructions are consumed per cycle. `in_take` gives the count. Lane k's fields are `in_valid[k]`, `in_tag[k*6 +: 6]` and `in_cnt[k*4 +: 4]`, with lane 0 the oldest. A lane is considered only when all older lanes are valid.
- R2: At most six slots are valid in any cycle. The oldest instruction with four micro-ops plus two single-micro-op instructions fill all six.
- R3: Lane 0 emits min(remaining, 4) slots in slots 0 upward. Each carries lane 0's tag. Their indices count up by one from the micro-ops already issued for that instruction. The last flag is set only on the slot whose index equals count-1.
- R4: If more than four micro-ops of lane 0 remain, four are emitted and nothing is consumed. Younger lanes emit nothing. The next ready cycle continues at index +4.
- R5: Lanes 1 and 2 are accepted only with a count of exactly 1, and only when every older lane is also consumed this cycle. A rejected lane blocks all younger lanes.
- R6: Slot s uses `slot_tag[s*6 +: 6]` and `slot_idx[s*4 +: 4]`. Valid slots are contiguous from slot 0 in program order: lane 0's micro-ops first, then lane 1, then lane 2. Younger single micro-ops have index 0 and the last flag set.
- R7: While `out_ready` is low, no slot is valid, `in_take` is 0, `err` is low, and the split offset holds.
- R8: A lane-0 instruction with count 0 raises `err` for that cycle. It is consumed (`in_take`=1) with no slot emitted, and younger lanes are not taken that cycle.
- R9: Reset clears the split offset, so the first slot after reset has index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_ready | input | 1 | Downstream can accept slots this cycle |
| in_valid | input | 3 | Queue entry valid, bit 0 oldest |
| in_tag | input | 18 | Three 6-bit instruction tags |
| in_cnt | input | 12 | Three 4-bit micro-op counts |
| in_take | output | 2 | Number of queue entries consumed this cycle |
| slot_valid | output | 6 | Slot valid bits, packed from bit 0 |
| slot_tag | output | 36 | Parent tag per slot |
| slot_idx | output | 24 | Index of the micro-op inside its parent |
| slot_last | output | 6 | Slot is its parent's final micro-op |
| err | output | 1 | Zero-count instruction dropped this cycle |

## Verification
Two pairs of functions overlap in one cycle. The first is a split continuation paired with younger lanes: the closing chunk of a nine-micro-op instruction shares its cycle with two single-micro-op followers. The bench checks that the chunk's index starts at 8 and that the followers pack into slots 1 and 2 with `in_take` of 3. The second is a stall landing inside a split. Ready is dropped between chunks for two cycles, and the next chunk must resume at index 4 rather than restart or skip.

// File: rtl/uop_alloc_pkg.sv
package uop_alloc_pkg;

   typedef enum logic [1:0] {
      HEAD_IDLE    = 2'd0,
      HEAD_SPLIT   = 2'd1,
      HEAD_FINISH  = 2'd2,
      HEAD_ILLEGAL = 2'd3
   } head_act_e;

endpackage

// File: rtl/uop_head_lane.sv
module uop_head_lane
   import uop_alloc_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int HEAD_MAX = 4
) (
   input  logic             valid,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] done,
   output head_act_e        act,
   output logic [CNT_W-1:0] n_emit,
   output logic [CNT_W-1:0] next_done
);
   localparam logic [CNT_W-1:0] CHUNK = CNT_W'(HEAD_MAX);

   logic [CNT_W-1:0] remaining;
   assign remaining = cnt - done;

   always_comb begin
      act       = HEAD_IDLE;
      n_emit    = '0;
      next_done = done;
      if (valid) begin
         if (cnt == '0) begin
            act       = HEAD_ILLEGAL;
            next_done = '0;
         end else if (remaining > CHUNK) begin
            act       = HEAD_SPLIT;
            n_emit    = CHUNK;
            next_done = done + CHUNK;
         end else begin
            act       = HEAD_FINISH;
            n_emit    = remaining;
            next_done = '0;
         end
      end
   end
endmodule

// File: rtl/uop_side_gate.sv
module uop_side_gate #(
   parameter int SIDE      = 2,
   parameter int CNT_W     = 4,
   parameter int MAX_TOTAL = 6
) (
   input  logic                  head_done,
   input  logic [CNT_W-1:0]      head_n,
   input  logic [SIDE-1:0]       valid,
   input  logic [SIDE*CNT_W-1:0] cnt,
   output logic [SIDE-1:0]       accept
);
   logic [SIDE-1:0] chain;

   for (genvar k = 0; k < SIDE; k++) begin : g_lane
      logic single, room;
      if (k == 0) begin : g_first
         assign chain[k] = head_done;
      end else begin : g_next
         assign chain[k] = accept[k-1];
      end
      assign single    = cnt[k*CNT_W +: CNT_W] == CNT_W'(1);
      assign room      = (int'(head_n) + k + 1) <= MAX_TOTAL;
      assign accept[k] = chain[k] & valid[k] & single & room;
   end
endmodule

// File: rtl/uop_slot_pack.sv
module uop_slot_pack #(
   parameter int LANES    = 3,
   parameter int SLOTS    = 6,
   parameter int HEAD_MAX = 4,
   parameter int TAG_W    = 6,
   parameter int CNT_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       head_n,
   input  logic [CNT_W-1:0]       head_base,
   input  logic [CNT_W-1:0]       head_cnt,
   input  logic [LANES*TAG_W-1:0] tags,
   input  logic [LANES-2:0]       side_acc,
   output logic [SLOTS-1:0]       slot_valid,
   output logic [SLOTS*TAG_W-1:0] slot_tag,
   output logic [SLOTS*CNT_W-1:0] slot_idx,
   output logic [SLOTS-1:0]       slot_last
);
   logic [TAG_W-1:0] t_a [SLOTS];
   logic [CNT_W-1:0] i_a [SLOTS];

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         slot_valid[s] = 1'b0;
         slot_last[s]  = 1'b0;
         t_a[s]        = '0;
         i_a[s]        = '0;
      end
      for (int s = 0; s < HEAD_MAX; s++) begin
         if (s < int'(head_n)) begin
            slot_valid[s] = 1'b1;
            t_a[s]        = tags[TAG_W-1:0];
            i_a[s]        = head_base + CNT_W'(s);
            slot_last[s]  = (head_base + CNT_W'(s)) == (head_cnt - 1'b1);
         end
      end
      for (int k = 0; k < LANES-1; k++) begin
         if (side_acc[k] && (int'(head_n) + k) < SLOTS) begin
            slot_valid[int'(head_n)+k] = 1'b1;
            t_a[int'(head_n)+k]        = tags[(k+1)*TAG_W +: TAG_W];
            i_a[int'(head_n)+k]        = '0;
            slot_last[int'(head_n)+k]  = 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_flat
      assign slot_tag[s*TAG_W +: TAG_W] = t_a[s];
      assign slot_idx[s*CNT_W +: CNT_W] = i_a[s];
   end

   // R6: valid slots form one run starting at slot 0
   assert_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((SLOTS'(slot_valid + 1'b1)) & slot_valid) == '0);
   // R3: an invalid slot never carries a last flag
   assert_last_in_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_last & ~slot_valid) == '0);
endmodule

// File: rtl/uop_slot_alloc.sv
module uop_slot_alloc
   import uop_alloc_pkg::*;
#(
   parameter int LANES     = 3,
   parameter int HEAD_MAX  = 4,
   parameter int MAX_TOTAL = 6,
   parameter int TAG_W     = 6,
   parameter int CNT_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       out_ready,
   input  logic [LANES-1:0]           in_valid,
   input  logic [LANES*TAG_W-1:0]     in_tag,
   input  logic [LANES*CNT_W-1:0]     in_cnt,
   output logic [$clog2(LANES+1)-1:0] in_take,
   output logic [MAX_TOTAL-1:0]       slot_valid,
   output logic [MAX_TOTAL*TAG_W-1:0] slot_tag,
   output logic [MAX_TOTAL*CNT_W-1:0] slot_idx,
   output logic [MAX_TOTAL-1:0]       slot_last,
   output logic                       err
);
   localparam int SLOTS  = MAX_TOTAL;
   localparam int SIDE   = LANES - 1;
   localparam int TAKE_W = $clog2(LANES + 1);

   if (LANES < 2)                     begin : g_chk_lanes  $error("LANES must be at least 2"); end
   if (HEAD_MAX > MAX_TOTAL)          begin : g_chk_budget $error("HEAD_MAX exceeds MAX_TOTAL"); end
   if (HEAD_MAX >= (1 << CNT_W))      begin : g_chk_cnt    $error("CNT_W too narrow for HEAD_MAX"); end

   logic [CNT_W-1:0] done_q, done_d, head_n;
   head_act_e        act;
   logic [SIDE-1:0]  side_acc;
   logic [LANES-1:0] live;
   logic             head_consumed;

   assign live = in_valid & {LANES{out_ready}};

   uop_head_lane #(.CNT_W(CNT_W), .HEAD_MAX(HEAD_MAX)) u_head (
      .valid     (live[0]),
      .cnt       (in_cnt[CNT_W-1:0]),
      .done      (done_q),
      .act       (act),
      .n_emit    (head_n),
      .next_done (done_d)
   );

   uop_side_gate #(.SIDE(SIDE), .CNT_W(CNT_W), .MAX_TOTAL(MAX_TOTAL)) u_side (
      .head_done (act == HEAD_FINISH),
      .head_n    (head_n),
      .valid     (live[LANES-1:1]),
      .cnt       (in_cnt[LANES*CNT_W-1:CNT_W]),
      .accept    (side_acc)
   );

   uop_slot_pack #(.LANES(LANES), .SLOTS(SLOTS), .HEAD_MAX(HEAD_MAX),
                   .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_n     (head_n),
      .head_base  (done_q),
      .head_cnt   (in_cnt[CNT_W-1:0]),
      .tags       (in_tag),
      .side_acc   (side_acc),
      .slot_valid (slot_valid),
      .slot_tag   (slot_tag),
      .slot_idx   (slot_idx),
      .slot_last  (slot_last)
   );

   assign head_consumed = (act == HEAD_FINISH) || (act == HEAD_ILLEGAL);
   assign in_take       = TAKE_W'(head_consumed) + TAKE_W'($countones(side_acc));
   assign err           = (act == HEAD_ILLEGAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= '0;
      else        done_q <= done_d;
   end

   // R7: a stalled cycle emits and consumes nothing
   assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> (slot_valid == '0 && in_take == '0 && !err));
   // R7: split offset frozen across a stalled cycle
   assert_hold_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> done_q == $past(done_q));
   // R4: a chunk without a last flag means nothing leaves the queue
   assert_split_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid[0] && slot_last == '0) |-> in_take == '0);
   // R8: dropped instruction produces no slot and exactly one pop
   assert_err_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (slot_valid == '0 && in_take == TAKE_W'(1)));
   // R2: slot count never exceeds the per-cycle budget
   assert_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_valid) <= int'(head_n) + SIDE);
endmodule

// File: tb/tb_uop_slot_alloc.sv
module tb_uop_slot_alloc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        out_ready = 1'b0;
   logic [2:0]  in_valid = '0;
   logic [17:0] in_tag = '0;
   logic [11:0] in_cnt = '0;
   logic [1:0]  in_take;
   logic [5:0]  slot_valid, slot_last;
   logic [35:0] slot_tag;
   logic [23:0] slot_idx;
   logic        err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   uop_slot_alloc dut (
      .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .in_valid(in_valid),
      .in_tag(in_tag), .in_cnt(in_cnt), .in_take(in_take), .slot_valid(slot_valid),
      .slot_tag(slot_tag), .slot_idx(slot_idx), .slot_last(slot_last), .err(err)
   );

   typedef struct packed {
      logic [2:0] v;
      logic [5:0] t0, t1, t2;
      logic [3:0] c0, c1, c2;
      logic       rdy;
      logic [1:0] e_take;
      logic [2:0] e_n;
      logic [3:0] e_idx;
      logic [5:0] e_last;
      logic       e_err;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      {3'b111, 6'd1,  6'd2,  6'd3,  4'd1, 4'd1, 4'd1, 1'b1, 2'd3, 3'd3, 4'd0, 6'b000111, 1'b0, 8'd1}, // R1
      {3'b111, 6'd4,  6'd5,  6'd6,  4'd3, 4'd1, 4'd1, 1'b1, 2'd3, 3'd5, 4'd0, 6'b011100, 1'b0, 8'd6}, // R6
      {3'b111, 6'd7,  6'd8,  6'd9,  4'd4, 4'd1, 4'd1, 1'b1, 2'd3, 3'd6, 4'd0, 6'b111000, 1'b0, 8'd2}, // R2
      {3'b111, 6'd10, 6'd11, 6'd12, 4'd9, 4'd1, 4'd1, 1'b1, 2'd0, 3'd4, 4'd0, 6'b000000, 1'b0, 8'd4}, // R4
      {3'b111, 6'd10, 6'd11, 6'd12, 4'd9, 4'd1, 4'd1, 1'b1, 2'd0, 3'd4, 4'd4, 6'b000000, 1'b0, 8'd4}, // R4
      {3'b111, 6'd10, 6'd11, 6'd12, 4'd9, 4'd1, 4'd1, 1'b1, 2'd3, 3'd3, 4'd8, 6'b000111, 1'b0, 8'd4}, // R4
      {3'b111, 6'd13, 6'd14, 6'd15, 4'd2, 4'd2, 4'd1, 1'b1, 2'd1, 3'd2, 4'd0, 6'b000010, 1'b0, 8'd5}, // R5
      {3'b001, 6'd14, 6'd0,  6'd0,  4'd2, 4'd0, 4'd0, 1'b1, 2'd1, 3'd2, 4'd0, 6'b000010, 1'b0, 8'd5}, // R5
      {3'b111, 6'd16, 6'd17, 6'd18, 4'd0, 4'd1, 4'd1, 1'b1, 2'd1, 3'd0, 4'd0, 6'b000000, 1'b1, 8'd8}, // R8
      {3'b111, 6'd17, 6'd18, 6'd19, 4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 3'd0, 4'd0, 6'b000000, 1'b0, 8'd7}, // R7
      {3'b000, 6'd17, 6'd18, 6'd19, 4'd1, 4'd1, 4'd1, 1'b1, 2'd0, 3'd0, 4'd0, 6'b000000, 1'b0, 8'd1}, // R1
      {3'b011, 6'd20, 6'd21, 6'd0,  4'd1, 4'd1, 4'd5, 1'b1, 2'd2, 3'd2, 4'd0, 6'b000011, 1'b0, 8'd5}, // R5
      {3'b111, 6'd22, 6'd23, 6'd24, 4'd1, 4'd3, 4'd1, 1'b1, 2'd1, 3'd1, 4'd0, 6'b000001, 1'b0, 8'd5}, // R5
      {3'b111, 6'd23, 6'd24, 6'd25, 4'd3, 4'd1, 4'd1, 1'b1, 2'd3, 3'd5, 4'd0, 6'b011100, 1'b0, 8'd6}  // R6
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] v, input logic [5:0] t0, t1, t2,
                        input logic [3:0] c0, c1, c2, input logic rdy);
      in_valid  = v;
      in_tag    = {t2, t1, t0};
      in_cnt    = {c2, c1, c0};
      out_ready = rdy;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: reset state, offset cleared so a long head starts at index 0
      @(negedge clk);
      drive(3'b001, 6'd40, 6'd0, 6'd0, 4'd9, 4'd0, 4'd0, 1'b1);
      #5;
      chk("R9", "reset idx0", int'(slot_idx[3:0]), 0);
      chk("R9", "reset take", int'(in_take), 0);
      @(negedge clk);
      drive(3'b000, 6'd0, 6'd0, 6'd0, 4'd0, 4'd0, 4'd0, 1'b0);
      rst_n = 1'b1;

      // vector table walk (stateful order)
      for (int i = 0; i < NV; i++) begin
         string r;
         @(negedge clk);
         drive(VEC[i].v, VEC[i].t0, VEC[i].t1, VEC[i].t2,
               VEC[i].c0, VEC[i].c1, VEC[i].c2, VEC[i].rdy);
         #5;
         r = $sformatf("R%0d vec%0d", VEC[i].req, i);
         chk(r, "take", int'(in_take), int'(VEC[i].e_take));
         chk(r, "nslots", $countones(slot_valid), int'(VEC[i].e_n));
         chk(r, "err", int'(err), int'(VEC[i].e_err));
         chk(r, "lastmask", int'(slot_last), int'(VEC[i].e_last));
         if (VEC[i].e_n != 0) begin
            chk(r, "idx0", int'(slot_idx[3:0]), int'(VEC[i].e_idx));
            chk(r, "tag0", int'(slot_tag[5:0]), int'(VEC[i].t0));
         end
      end

      // R3: four-uop head alone, indices 0..3, last only on slot 3
      @(negedge clk);
      drive(3'b001, 6'd33, 6'd0, 6'd0, 4'd4, 4'd0, 4'd0, 1'b1);
      #5;
      chk("R3", "idx vector", int'(slot_idx[15:0]), 16'h3210);
      chk("R3", "tags", int'(slot_tag[23:0]), int'({6'd33, 6'd33, 6'd33, 6'd33}));
      chk("R3", "last", int'(slot_last), 6'b001000);

      // R6: split tail with followers packs into slots 1,2
      @(negedge clk);
      drive(3'b111, 6'd50, 6'd51, 6'd52, 4'd5, 4'd1, 4'd1, 1'b1);
      #5;
      chk("R4", "first chunk take", int'(in_take), 0);
      @(negedge clk);
      #5;
      chk("R6", "tail idx", int'(slot_idx[3:0]), 4);
      chk("R6", "slot1 tag", int'(slot_tag[11:6]), 51);
      chk("R6", "slot2 tag", int'(slot_tag[17:12]), 52);
      chk("R6", "slot1 idx", int'(slot_idx[7:4]), 0);
      chk("R6", "take", int'(in_take), 3);

      // R7: stall in the middle of a split, resumes at index 4
      @(negedge clk);
      drive(3'b001, 6'd60, 6'd0, 6'd0, 4'd9, 4'd0, 4'd0, 1'b1);
      #5;
      chk("R4", "chunk0 idx", int'(slot_idx[3:0]), 0);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         out_ready = 1'b0;
         #5;
         chk("R7", "stall slots", int'(slot_valid), 0);
         chk("R7", "stall take", int'(in_take), 0);
      end
      @(negedge clk);
      out_ready = 1'b1;
      #5;
      chk("R7", "resume idx", int'(slot_idx[3:0]), 4);
      chk("R7", "resume tag", int'(slot_tag[5:0]), 60);
      @(negedge clk);
      #5;
      chk("R4", "final idx", int'(slot_idx[3:0]), 8);
      chk("R4", "final last", int'(slot_last), 6'b000001);
      chk("R4", "final take", int'(in_take), 1);

      // R8 with R7: zero count while stalled raises nothing
      @(negedge clk);
      drive(3'b001, 6'd61, 6'd0, 6'd0, 4'd0, 4'd0, 4'd0, 1'b0);
      #5;
      chk("R8", "err gated by ready", int'(err), 0);

      // R9: reset in the middle of a split restarts at index 0
      @(negedge clk);
      drive(3'b001, 6'd62, 6'd0, 6'd0, 4'd9, 4'd0, 4'd0, 1'b1);
      @(negedge clk);
      #5;
      chk("R9", "pre-reset idx", int'(slot_idx[3:0]), 4);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      chk("R9", "post-reset idx", int'(slot_idx[3:0]), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule